// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a register bus and the write/erase engine of an on-chip flash array. Software first selects an operation by writing a command code into a control register. The write only counts when it carries a fixed key value in the same access. Selecting a command does not start anything; it only arms the block. The operation begins when software then writes a data word to an address in the array. At that point the block launches a one-cycle start request to the flash engine, carrying the command, the address and the data. It then holds itself busy until the engine returns a done pulse.

A write-protect bit guards the command register, and software clears it around each command. The block also refuses a command that arrives while an operation runs, a reserved code, and a whole-array erase while the debug access level input is zero. Each refusal sets a sticky error bit that software clears by writing 1 to it. Completion sets a sticky done flag, which can drive an interrupt line. A ready level shows whether the engine is idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write to register 0 changes the armed command (bits 3:0) only when bits 15:8 of the same write equal the key 0xA5. A write with any other key leaves the armed command and the error bit unchanged. Reading register 0 returns the armed command in bits 3:0. Reset arms command 0.
- R2: Register 3 holds the write-protect bit in bit 0, which resets to 1, and the interrupt enable in bit 1, which resets to 0. While write-protect is 1, writes to register 0 change neither the armed command nor the error bit.
- R3: An accepted command does not start an operation. An array write made while idle with a non-zero command armed raises `flash_start_o` for exactly the cycle after the write, with `flash_op_o`, `flash_addr_o` and `flash_data_o` set to the armed code and the written address and data. `ready_o` and register 1 bit 0 drop to 0 in that same cycle.
- R4: Ready stays 0 until `flash_done_i` is sampled high, and it is 1 in the cycle after that sample. The armed command stays armed after completion.
- R5: A keyed, unprotected command write made while ready is 0 is discarded and sets the error bit (register 2 bit 0). This also applies to a write made in the same cycle as an array write that starts an operation.
- R6: Command code 0 (no operation) clears the armed command. An array write with code 0 armed starts nothing and sets the error bit. An array write while busy also starts nothing and sets the error bit.
- R7: Code 3 (whole-array erase) is rejected with the error bit set, and the armed command left unchanged, while `dbg_lvl_i` is 0. At any non-zero level it is accepted.
- R8: Codes 4 to 15 are rejected: the error bit is set and the armed command is left unchanged. Code 1 is word write and code 2 is page erase.
- R9: Completion sets the done flag (register 1 bit 1), which stays set until 1 is written to that bit. `irq_o` equals the done flag ANDed with the interrupt enable. If completion and the clear fall in the same cycle, the flag stays set.
- R10: The error bit stays set until 1 is written to register 2 bit 0. If a new error and the clear fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index (0 command, 1 flags, 2 status, 3 config) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| arr_we_i | input | 1 | Array write strobe (operation trigger) |
| arr_addr_i | input | AW | Array write address |
| arr_wdata_i | input | DW | Array write data |
| dbg_lvl_i | input | 2 | Debug access level |
| flash_done_i | input | 1 | Completion pulse from the flash engine |
| flash_start_o | output | 1 | One-cycle start request to the flash engine |
| flash_op_o | output | 4 | Command code of the launched operation |
| flash_addr_o | output | AW | Address of the launched operation |
| flash_data_o | output | DW | Data of the launched operation |
| ready_o | output | 1 | High while no operation is running |
| irq_o | output | 1 | Done interrupt |

## Verification
Two collisions can happen in a single cycle. The first is a keyed command write arriving with the array write that launches an operation. The bench drives both strobes on the same edge and expects the launch to use the old command, the command register to keep that old code, and the error bit to be set. The second is a sticky flag being set and cleared in the same cycle. The bench pulses done while writing 1 to the done flag, and raises an error from an empty-command array write while clearing the error bit. It expects both flags to read back as set.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NOOP       = 4'd0,
    CMD_WRITE      = 4'd1,
    CMD_PAGE_ERASE = 4'd2,
    CMD_CHIP_ERASE = 4'd3
  } cmd_e;

  localparam logic [1:0] REG_CMD    = 2'd0;
  localparam logic [1:0] REG_FLAGS  = 2'd1;
  localparam logic [1:0] REG_STATUS = 2'd2;
  localparam logic [1:0] REG_CFG    = 2'd3;

  localparam int CMD_W   = 4;
  localparam int KEY_LSB = 8;
  localparam int KEY_W   = 8;
  localparam int REG_W   = 32;
endpackage

// File: rtl/flash_cmd_op.sv
module flash_cmd_op
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arr_we_i,
  input  logic [AW-1:0]    arr_addr_i,
  input  logic [DW-1:0]    arr_wdata_i,
  input  logic [CMD_W-1:0] armed_cmd_i,
  input  logic             flash_done_i,
  output logic             busy_o,
  output logic             start_evt_o,
  output logic             done_evt_o,
  output logic             arr_err_o,
  output logic             flash_start_o,
  output logic [CMD_W-1:0] flash_op_o,
  output logic [AW-1:0]    flash_addr_o,
  output logic [DW-1:0]    flash_data_o
);
  logic busy_q, start_q;

  assign start_evt_o = arr_we_i && !busy_q && (armed_cmd_i != CMD_NOOP);
  assign arr_err_o   = arr_we_i && !start_evt_o;
  assign done_evt_o  = flash_done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      start_q      <= 1'b0;
      flash_op_o   <= '0;
      flash_addr_o <= '0;
      flash_data_o <= '0;
    end else begin
      start_q <= start_evt_o;
      if (start_evt_o) begin
        busy_q       <= 1'b1;
        flash_op_o   <= armed_cmd_i;
        flash_addr_o <= arr_addr_i;
        flash_data_o <= arr_wdata_i;
      end else if (done_evt_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o        = busy_q;
  assign flash_start_o = start_q;
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic [1:0]       dbg_lvl_i,
  input  logic             busy_i,
  input  logic             start_evt_i,
  input  logic             done_evt_i,
  input  logic             arr_err_i,
  output logic [CMD_W-1:0] armed_cmd_o,
  output logic             wp_en_o,
  output logic             err_o,
  output logic             irq_o,
  output logic [REG_W-1:0] reg_rdata_o
);
  logic [CMD_W-1:0] armed_q;
  logic             wp_q, irq_en_q, done_q, err_q;
  logic [CMD_W-1:0] new_cmd;
  logic             cmd_wr, cmd_bad, cmd_take, cmd_rej;
  logic             wr_flags, wr_status, wr_cfg;
  logic             unused_wdata;

  assign new_cmd   = reg_wdata_i[CMD_W-1:0];
  assign cmd_wr    = reg_we_i && (reg_addr_i == REG_CMD) && !wp_q &&
                     (reg_wdata_i[KEY_LSB +: KEY_W] == KEY);
  // the launch cycle already counts as busy
  assign cmd_bad   = busy_i || start_evt_i || (new_cmd > CMD_CHIP_ERASE) ||
                     ((new_cmd == CMD_CHIP_ERASE) && (dbg_lvl_i == 2'd0));
  assign cmd_take  = cmd_wr && !cmd_bad;
  assign cmd_rej   = cmd_wr && cmd_bad;
  assign wr_flags  = reg_we_i && (reg_addr_i == REG_FLAGS);
  assign wr_status = reg_we_i && (reg_addr_i == REG_STATUS);
  assign wr_cfg    = reg_we_i && (reg_addr_i == REG_CFG);

  assign unused_wdata = ^{reg_wdata_i[REG_W-1:KEY_LSB+KEY_W],
                          reg_wdata_i[KEY_LSB-1:CMD_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= CMD_NOOP;
      wp_q     <= 1'b1;
      irq_en_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (cmd_take) armed_q <= new_cmd;
      if (wr_cfg) begin
        wp_q     <= reg_wdata_i[0];
        irq_en_q <= reg_wdata_i[1];
      end
      // set wins over write-one-to-clear
      if (done_evt_i)                    done_q <= 1'b1;
      else if (wr_flags && reg_wdata_i[1]) done_q <= 1'b0;
      if (cmd_rej || arr_err_i)            err_q <= 1'b1;
      else if (wr_status && reg_wdata_i[0]) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CMD:    reg_rdata_o[CMD_W-1:0] = armed_q;
      REG_FLAGS:  reg_rdata_o[1:0]       = {done_q, !busy_i};
      REG_STATUS: reg_rdata_o[0]         = err_q;
      default:    reg_rdata_o[1:0]       = {irq_en_q, wp_q};
    endcase
  end

  assign armed_cmd_o = armed_q;
  assign wp_en_o     = wp_q;
  assign err_o       = err_q;
  assign irq_o       = done_q && irq_en_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          arr_we_i,
  input  logic [AW-1:0] arr_addr_i,
  input  logic [DW-1:0] arr_wdata_i,
  input  logic [1:0]    dbg_lvl_i,
  input  logic          flash_done_i,
  output logic          flash_start_o,
  output logic [3:0]    flash_op_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [DW-1:0] flash_data_o,
  output logic          ready_o,
  output logic          irq_o
);
  logic [CMD_W-1:0] armed_cmd;
  logic             busy, start_evt, done_evt, arr_err, wp_en, err_flag;

  flash_cmd_op #(.AW(AW), .DW(DW)) u_op (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arr_we_i     (arr_we_i),
    .arr_addr_i   (arr_addr_i),
    .arr_wdata_i  (arr_wdata_i),
    .armed_cmd_i  (armed_cmd),
    .flash_done_i (flash_done_i),
    .busy_o       (busy),
    .start_evt_o  (start_evt),
    .done_evt_o   (done_evt),
    .arr_err_o    (arr_err),
    .flash_start_o(flash_start_o),
    .flash_op_o   (flash_op_o),
    .flash_addr_o (flash_addr_o),
    .flash_data_o (flash_data_o)
  );

  flash_cmd_regs #(.KEY(KEY)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .dbg_lvl_i   (dbg_lvl_i),
    .busy_i      (busy),
    .start_evt_i (start_evt),
    .done_evt_i  (done_evt),
    .arr_err_i   (arr_err),
    .armed_cmd_o (armed_cmd),
    .wp_en_o     (wp_en),
    .err_o       (err_flag),
    .irq_o       (irq_o),
    .reg_rdata_o (reg_rdata_o)
  );

  assign ready_o = !busy;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter logic [7:0] KEY = 8'hA5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        arr_we_i,
  input logic [1:0]  dbg_lvl_i,
  input logic        flash_done_i,
  input logic        flash_start_o,
  input logic        ready_o,
  input logic [3:0]  armed_cmd,
  input logic        wp_en,
  input logic        err_flag
);
  logic keyed_cmd;
  assign keyed_cmd = reg_we_i && (reg_addr_i == 2'd0) && (reg_wdata_i[15:8] == KEY);

  assert_bad_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[15:8] != KEY) |=> $stable(armed_cmd));

  assert_protected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keyed_cmd && wp_en) |=> $stable(armed_cmd));

  assert_start_after_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_start_o |-> ($past(arr_we_i) && !ready_o));

  assert_busy_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !flash_done_i) |=> !ready_o);

  assert_busy_cmd_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keyed_cmd && !wp_en && !ready_o) |=> (err_flag && $stable(armed_cmd)));

  assert_chip_erase_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keyed_cmd && !wp_en && reg_wdata_i[3:0] == 4'd3 && dbg_lvl_i == 2'd0)
      |=> (err_flag && $stable(armed_cmd)));

  assert_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keyed_cmd && !wp_en && reg_wdata_i[3:0] > 4'd3) |=> (err_flag && $stable(armed_cmd)));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.KEY(KEY)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .arr_we_i     (arr_we_i),
  .dbg_lvl_i    (dbg_lvl_i),
  .flash_done_i (flash_done_i),
  .flash_start_o(flash_start_o),
  .ready_o      (ready_o),
  .armed_cmd    (armed_cmd),
  .wp_en        (wp_en),
  .err_flag     (err_flag)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          reg_we_i;
  logic [1:0]    reg_addr_i;
  logic [31:0]   reg_wdata_i;
  logic [31:0]   reg_rdata_o;
  logic          arr_we_i;
  logic [AW-1:0] arr_addr_i;
  logic [DW-1:0] arr_wdata_i;
  logic [1:0]    dbg_lvl_i;
  logic          flash_done_i;
  logic          flash_start_o;
  logic [3:0]    flash_op_o;
  logic [AW-1:0] flash_addr_o;
  logic [DW-1:0] flash_data_o;
  logic          ready_o;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 0;

  always #4 clk_i = ~clk_i;

  flash_cmd_seq #(.AW(AW), .DW(DW)) uut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic cmd_wr(input logic [3:0] c);
    reg_wr(2'd0, {16'h0, 8'hA5, 4'h0, c});
  endtask

  task automatic arr_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    arr_we_i = 1'b1; arr_addr_i = a; arr_wdata_i = d;
    @(negedge clk_i);
    arr_we_i = 1'b0;
  endtask

  task automatic finish_op(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      check("R4", "ready held low", {31'b0, ready_o}, 32'd0);
    end
    flash_done_i = 1'b1;
    @(negedge clk_i);
    flash_done_i = 1'b0;
    check("R4", "ready after done", {31'b0, ready_o}, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R4", "reset ready", {31'b0, ready_o}, 32'd1);
    check("R9", "reset irq", {31'b0, irq_o}, 32'd0);
    reg_rd(2'd0, d); check("R1", "reset cmd", d, 32'd0);
    reg_rd(2'd1, d); check("R9", "reset flags", d, 32'd1);
    reg_rd(2'd2, d); check("R10", "reset err", d, 32'd0);
    reg_rd(2'd3, d); check("R2", "reset cfg", d, 32'd1);
  endtask

  task automatic t_key_protect;
    logic [31:0] d;
    cmd_wr(4'd1);
    reg_rd(2'd0, d); check("R2", "protected cmd", d, 32'd0);
    reg_rd(2'd2, d); check("R2", "protected no err", d, 32'd0);
    reg_wr(2'd3, 32'd0);
    reg_wr(2'd0, 32'h0000_5A01);
    reg_rd(2'd0, d); check("R1", "bad key cmd", d, 32'd0);
    reg_rd(2'd2, d); check("R1", "bad key no err", d, 32'd0);
    cmd_wr(4'd1);
    reg_rd(2'd0, d); check("R1", "good key cmd", d, 32'd1);
    check("R3", "no start on arm", {31'b0, flash_start_o}, 32'd0);
    check("R3", "ready on arm", {31'b0, ready_o}, 32'd1);
  endtask

  task automatic t_write_op;
    logic [31:0] d;
    arr_wr(16'h1234, 32'hCAFE_F00D);
    check("R3", "start pulse", {31'b0, flash_start_o}, 32'd1);
    check("R3", "op code", {28'b0, flash_op_o}, 32'd1);
    check("R3", "op addr", {16'b0, flash_addr_o}, 32'h1234);
    check("R3", "op data", flash_data_o, 32'hCAFE_F00D);
    check("R3", "ready drop", {31'b0, ready_o}, 32'd0);
    reg_rd(2'd1, d); check("R3", "flags ready bit", d, 32'd0);
    finish_op(5);
    check("R3", "start one cycle", {31'b0, flash_start_o}, 32'd0);
    reg_rd(2'd1, d); check("R9", "done flag", d, 32'd3);
    reg_rd(2'd0, d); check("R4", "cmd kept armed", d, 32'd1);
    check("R9", "irq masked", {31'b0, irq_o}, 32'd0);
    reg_wr(2'd3, 32'd2);
    check("R9", "irq enabled", {31'b0, irq_o}, 32'd1);
    reg_wr(2'd1, 32'd2);
    check("R9", "irq cleared", {31'b0, irq_o}, 32'd0);
    reg_rd(2'd1, d); check("R9", "done cleared", d, 32'd1);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    arr_wr(16'h0010, 32'h1);
    cmd_wr(4'd2);
    reg_rd(2'd2, d); check("R5", "busy cmd err", d, 32'd1);
    reg_rd(2'd0, d); check("R5", "busy cmd dropped", d, 32'd1);
    arr_wr(16'h0020, 32'h2);
    check("R6", "no restart while busy", {31'b0, flash_start_o}, 32'd0);
    check("R6", "addr unchanged", {16'b0, flash_addr_o}, 32'h0010);
    finish_op(2);
    reg_wr(2'd2, 32'd1);
    reg_rd(2'd2, d); check("R10", "err cleared", d, 32'd0);
  endtask

  task automatic t_noop;
    logic [31:0] d;
    cmd_wr(4'd0);
    reg_rd(2'd0, d); check("R6", "noop armed", d, 32'd0);
    arr_wr(16'h0040, 32'h4);
    check("R6", "noop no start", {31'b0, flash_start_o}, 32'd0);
    check("R6", "noop stays ready", {31'b0, ready_o}, 32'd1);
    reg_rd(2'd2, d); check("R6", "noop err", d, 32'd1);
    reg_rd(2'd2, d); check("R10", "err sticky", d, 32'd1);
    reg_wr(2'd2, 32'd1);
  endtask

  task automatic t_chip_erase;
    logic [31:0] d;
    dbg_lvl_i = 2'd0;
    cmd_wr(4'd3);
    reg_rd(2'd0, d); check("R7", "chip erase refused", d, 32'd0);
    reg_rd(2'd2, d); check("R7", "chip erase err", d, 32'd1);
    reg_wr(2'd2, 32'd1);
    dbg_lvl_i = 2'd1;
    cmd_wr(4'd3);
    reg_rd(2'd0, d); check("R7", "chip erase taken", d, 32'd3);
    reg_rd(2'd2, d); check("R7", "chip erase no err", d, 32'd0);
    arr_wr(16'h0000, 32'h0);
    check("R7", "chip erase op", {28'b0, flash_op_o}, 32'd3);
    finish_op(1);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    cmd_wr(4'd2);
    cmd_wr(4'd9);
    reg_rd(2'd0, d); check("R8", "reserved dropped", d, 32'd2);
    reg_rd(2'd2, d); check("R8", "reserved err", d, 32'd1);
    reg_wr(2'd2, 32'd1);
    cmd_wr(4'd15);
    reg_rd(2'd0, d); check("R8", "code 15 dropped", d, 32'd2);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    reg_wr(2'd2, 32'd1);
    cmd_wr(4'd1);
    arr_we_i = 1'b1; arr_addr_i = 16'h0055; arr_wdata_i = 32'h55;
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'h0000_A502;
    @(negedge clk_i);
    arr_we_i = 1'b0; reg_we_i = 1'b0;
    check("R5", "collide start", {31'b0, flash_start_o}, 32'd1);
    check("R5", "collide op old", {28'b0, flash_op_o}, 32'd1);
    reg_rd(2'd0, d); check("R5", "collide cmd kept", d, 32'd1);
    reg_rd(2'd2, d); check("R5", "collide err", d, 32'd1);
    reg_wr(2'd2, 32'd1);
    finish_op(1);
    arr_wr(16'h0066, 32'h66);
    repeat (2) @(negedge clk_i);
    flash_done_i = 1'b1;
    reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 32'd2;
    @(negedge clk_i);
    flash_done_i = 1'b0; reg_we_i = 1'b0;
    reg_rd(2'd1, d); check("R9", "set beats clear", d, 32'd3);
    cmd_wr(4'd0);
    arr_we_i = 1'b1;
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 32'd1;
    @(negedge clk_i);
    arr_we_i = 1'b0; reg_we_i = 1'b0;
    reg_rd(2'd2, d); check("R10", "err set beats clear", d, 32'd1);
  endtask

  task automatic summary;
    if (!done_run) begin
      done_run = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_ni = 1'b0; reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    arr_we_i = 1'b0; arr_addr_i = '0; arr_wdata_i = '0;
    dbg_lvl_i = 2'd0; flash_done_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_key_protect();
    t_write_op();
    t_busy();
    t_noop();
    t_chip_erase();
    t_reserved();
    t_collide();
    @(negedge clk_i);
    summary();
  end
endmodule